// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the synchronized input pins of a general-purpose I/O port into per-pin interrupt status and one combined interrupt line. Each pin has its own type bit and polarity bit, which together select one of four triggers: rising edge, falling edge, active-high level or active-low level. An edge event is held in a pending flag until software writes a one to that pin's end-of-interrupt bit. A level event is never stored; its status follows the pin.

Software controls each pin with an enable bit and a mask bit. A disabled pin reports nothing and loses any edge it had stored. A masked pin keeps detecting and still shows up in the raw status, but it is kept out of the masked status and out of the interrupt line.

Software can get an event on both edges by flipping a pin's polarity after each event. The detector compares the pin only with its own earlier sample and never with the polarity setting, so flipping the polarity cannot raise an event by itself. Debounce and register access belong to neighbouring blocks.

Top module: `gpio_irq_detect`

## Requirements
- R1: A type bit of 1 sets edge sensing for its pin and 0 sets level sensing. A pin in level mode keeps no stored edge: moving a pin to level mode discards any edge it held.
- R2: With edge sensing, a polarity bit of 1 detects a 0-to-1 change between the pin's previous and current samples, and 0 detects a 1-to-0 change. The event appears in the raw status one clock after the sample in which the pin changed.
- R3: A stored edge stays pending until an end-of-interrupt write carries a 1 in that pin's bit. A 0 bit in the write data, or a cycle with the write strobe low, leaves the flag as it is.
- R4: An end-of-interrupt write with all data bits set to 1 clears every pending edge in the same clock.
- R5: A mask bit of 1 forces that pin's masked-status bit to 0 and keeps it off the interrupt line. Its raw-status bit and its edge detection carry on unchanged.
- R6: A pin with its enable bit at 0 shows 0 in both status vectors and never drives the interrupt line. Any edge stored while the enable was 1 is discarded, so setting the enable again does not bring it back.
- R7: Changing a polarity bit while the pin stays still never creates an edge event.
- R8: When a new edge and an end-of-interrupt write for the same pin fall in the same clock, the new edge wins and the pin stays pending.
- R9: The interrupt output is a register. It holds the OR of the masked-status bits from the previous clock.
- R10: While reset is held, both status vectors read 0 if the enables are 0, and the interrupt output reads 0. The first sample taken after reset is released never counts as an edge.
- R11: With level sensing, the raw-status bit is the pin value when polarity is 1 and its inverse when polarity is 0. It changes in the same cycle as the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | WIDTH | Synchronized pin values |
| irq_en_i | input | WIDTH | Per-pin enable, 1 = enabled |
| irq_mask_i | input | WIDTH | Per-pin mask, 1 = masked |
| irq_edge_i | input | WIDTH | Per-pin type, 1 = edge, 0 = level |
| irq_pol_i | input | WIDTH | Per-pin polarity, 1 = rising or high, 0 = falling or low |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_data_i | input | WIDTH | End-of-interrupt data, 1 clears a pending edge |
| raw_stat_o | output | WIDTH | Status of enabled pins before masking |
| int_stat_o | output | WIDTH | Status after masking |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the detector with WIDTH set to 8, while elaboration alone uses the default of 32. With eight pins, each directed case can put a different trigger mode on each half of the vector in one test. A short pseudo-random run then reaches the all-ones end-of-interrupt pattern, mixed enable and mask settings, and edges that coincide with clears. A behavioural model of the pending flags and the interrupt register is compared with both status vectors and the interrupt line on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Edge seen on one pin: rise_sel picks 0->1 (1) or 1->0 (0).
  function automatic logic edge_seen(input logic now_v, input logic before_v,
                                     input logic rise_sel);
    logic rose;
    logic fell;
    rose = now_v & ~before_v;
    fell = ~now_v & before_v;
    return rise_sel ? rose : fell;
  endfunction

  // Level active on one pin: high_sel picks active-high (1) or active-low (0).
  function automatic logic level_seen(input logic now_v, input logic high_sel);
    return high_sel ? now_v : ~now_v;
  endfunction

  // Next value of one pending-edge flag. A fresh hit beats a clear.
  function automatic logic pend_step(input logic held, input logic hit,
                                     input logic clr, input logic en,
                                     input logic edge_mode);
    logic keep;
    keep = held & ~clr;
    return en & edge_mode & (keep | hit);
  endfunction

  // Status of one pin before masking.
  function automatic logic status_bit(input logic en, input logic edge_mode,
                                      input logic pend, input logic lvl);
    return en & (edge_mode ? pend : lvl);
  endfunction

endpackage

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] edge_hit_o,
  output logic [WIDTH-1:0] lvl_hit_o
);
  import gpio_irq_pkg::*;

  logic [WIDTH-1:0] prev_q;
  logic             primed_q;

  // History of the pins; the first sample after reset only primes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign edge_hit_o[b] = primed_q & edge_seen(pin_i[b], prev_q[b], pol_i[b]);
    assign lvl_hit_o[b]  = level_seen(pin_i[b], pol_i[b]);
  end

endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic             eoi_wr_i,
  input  logic [WIDTH-1:0] eoi_data_i,
  output logic [WIDTH-1:0] pend_o
);
  import gpio_irq_pkg::*;

  logic [WIDTH-1:0] clr;
  logic [WIDTH-1:0] pend_q;

  assign clr = eoi_wr_i ? eoi_data_i : '0;

  for (genvar b = 0; b < WIDTH; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= 1'b0;
      end else begin
        pend_q[b] <= pend_step(pend_q[b], hit_i[b], clr[b], en_i[b], edge_mode_i[b]);
      end
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] raw_o,
  output logic [WIDTH-1:0] masked_o,
  output logic             irq_o
);
  import gpio_irq_pkg::*;

  logic irq_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_stat
    assign raw_o[b] = status_bit(en_i[b], edge_mode_i[b], pend_i[b], lvl_i[b]);
  end

  assign masked_o = raw_o & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |masked_o;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] irq_en_i,
  input  logic [WIDTH-1:0] irq_mask_i,
  input  logic [WIDTH-1:0] irq_edge_i,
  input  logic [WIDTH-1:0] irq_pol_i,
  input  logic             eoi_wr_i,
  input  logic [WIDTH-1:0] eoi_data_i,
  output logic [WIDTH-1:0] raw_stat_o,
  output logic [WIDTH-1:0] int_stat_o,
  output logic             irq_o
);

  // Internal events brought out by name for the checker.
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] lvl_hit;
  logic [WIDTH-1:0] pend_q;

  gpio_irq_sense #(.WIDTH(WIDTH)) u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .pol_i      (irq_pol_i),
    .edge_hit_o (edge_hit),
    .lvl_hit_o  (lvl_hit)
  );

  gpio_irq_pending #(.WIDTH(WIDTH)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (edge_hit),
    .en_i        (irq_en_i),
    .edge_mode_i (irq_edge_i),
    .eoi_wr_i    (eoi_wr_i),
    .eoi_data_i  (eoi_data_i),
    .pend_o      (pend_q)
  );

  gpio_irq_combine #(.WIDTH(WIDTH)) u_comb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_q),
    .lvl_i       (lvl_hit),
    .en_i        (irq_en_i),
    .edge_mode_i (irq_edge_i),
    .mask_i      (irq_mask_i),
    .raw_o       (raw_stat_o),
    .masked_o    (int_stat_o),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] irq_en_i,
  input logic [WIDTH-1:0] irq_mask_i,
  input logic [WIDTH-1:0] irq_edge_i,
  input logic             eoi_wr_i,
  input logic [WIDTH-1:0] eoi_data_i,
  input logic [WIDTH-1:0] raw_stat_o,
  input logic [WIDTH-1:0] int_stat_o,
  input logic             irq_o,
  input logic [WIDTH-1:0] edge_hit,
  input logic [WIDTH-1:0] pend_q
);

  // Set after the first clock out of reset, so $past never reaches into reset.
  logic ran_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ran_q <= 1'b0;
    else        ran_q <= 1'b1;
  end

  assert_eoi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && eoi_wr_i) |=> ((pend_q & $past(eoi_data_i & ~edge_hit)) == '0));

  assert_all_ones_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && eoi_wr_i && (&eoi_data_i) && (edge_hit == '0)) |=> (pend_q == '0));

  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_stat_o & irq_mask_i) == '0);

  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat_o & ~irq_en_i) == '0);

  assert_disable_discards_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |=> ((pend_q & ~$past(irq_en_i)) == '0));

  assert_level_holds_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |=> ((pend_q & ~$past(irq_edge_i)) == '0));

  assert_still_pin_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && (pin_i == $past(pin_i))) |-> (edge_hit == '0));

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |=> ((pend_q & $past(edge_hit & irq_en_i & irq_edge_i))
               == $past(edge_hit & irq_en_i & irq_edge_i)));

  assert_irq_registered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |=> (irq_o == $past(|int_stat_o)));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_i      (pin_i),
  .irq_en_i   (irq_en_i),
  .irq_mask_i (irq_mask_i),
  .irq_edge_i (irq_edge_i),
  .eoi_wr_i   (eoi_wr_i),
  .eoi_data_i (eoi_data_i),
  .raw_stat_o (raw_stat_o),
  .int_stat_o (int_stat_o),
  .irq_o      (irq_o),
  .edge_hit   (edge_hit),
  .pend_q     (pend_q)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = '0, en = '0, mask = '0, typ = '0, pol = '0, eoi_d = '0;
  logic         eoi_wr = 1'b0;
  logic [W-1:0] raw, ist;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en), .irq_mask_i(mask),
    .irq_edge_i(typ), .irq_pol_i(pol), .eoi_wr_i(eoi_wr), .eoi_data_i(eoi_d),
    .raw_stat_o(raw), .int_stat_o(ist), .irq_o(irq)
  );

  // Behavioural reference: remembered pins, stored edges, interrupt register.
  bit         m_seen = 0;
  bit [W-1:0] m_last = '0;
  bit [W-1:0] m_held = '0;
  bit         m_irq = 0;

  function automatic bit [W-1:0] exp_raw();
    bit [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (!en[i])      r[i] = 0;
      else if (typ[i]) r[i] = m_held[i];
      else             r[i] = (pol[i] == pin[i]);
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_seen = 0; m_last = '0; m_held = '0; m_irq = 0;
    end else begin
      bit [W-1:0] masked_now;
      masked_now = exp_raw() & ~mask;
      for (int i = 0; i < W; i++) begin
        bit fresh;
        fresh = m_seen && (pin[i] != m_last[i]) && (pin[i] == pol[i]);
        if (!en[i] || !typ[i])          m_held[i] = 0;
        else if (fresh)                 m_held[i] = 1;
        else if (eoi_wr && eoi_d[i])    m_held[i] = 0;
      end
      m_irq  = (masked_now != 0);
      m_last = pin;
      m_seen = 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Compare with the model every cycle, after the inputs driven at the negedge settle.
  always @(negedge clk) begin
    #2;
    if (!done) begin
      bit [W-1:0] er;
      er = exp_raw();
      chk(tag, "raw", raw, er);
      chk(tag, "masked", ist, er & ~mask);
      chk(tag, "irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
    end
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic look(input string req, input logic [W-1:0] exp);
    #3;
    chk(req, "directed raw", raw, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] lf;
    // R10: reset state
    tag = "R10";
    cyc(3);
    look("R10", '0);
    chk("R10", "reset irq", {{(W-1){1'b0}}, irq}, '0);
    en = '1; typ = '1; pol = '1; pin = '1;
    cyc(1);
    rst_n = 1'b1;
    cyc(3);
    look("R10", '0);  // pins high since reset: no edge

    // R1 R2: falling on upper half, rising on lower half
    tag = "R2";
    cyc(1); pol = 8'h0F; pin = 8'h00;
    cyc(1); look("R2", 8'hF0);
    eoi_wr = 1; eoi_d = '1;
    cyc(1); eoi_wr = 0; pin = 8'hFF;
    cyc(1); look("R2", 8'h0F);
    cyc(2);

    // R1: switching to level mode discards stored edges
    tag = "R1";
    typ = 8'h00; pol = 8'h00;
    cyc(1); typ = '1;
    cyc(1); look("R1", 8'h00);

    // R11: level mode follows the pin
    tag = "R11";
    typ = 8'h00; pol = 8'h0F; pin = 8'h55;
    look("R11", 8'hA5);
    cyc(1); pin = 8'hAA;
    look("R11", 8'h5A);
    cyc(2);

    // R3: clear only bits written with 1
    tag = "R3";
    typ = '1; pol = '1; pin = 8'h00;
    cyc(1); pin = '1;
    cyc(1); look("R3", 8'hFF);
    eoi_wr = 1; eoi_d = 8'h00;
    cyc(1); eoi_wr = 0; look("R3", 8'hFF);
    eoi_d = 8'h0F;
    cyc(1); eoi_wr = 1;
    cyc(1); eoi_wr = 0; look("R3", 8'hF0);

    // R4: all ones clears everything
    tag = "R4";
    eoi_wr = 1; eoi_d = '1;
    cyc(1); eoi_wr = 0; look("R4", 8'h00);

    // R5: mask hides status but not detection
    tag = "R5";
    mask = 8'hF0; pin = 8'h00;
    cyc(1); pin = '1;
    cyc(1); look("R5", 8'hFF);
    cyc(2);
    mask = 8'h00;
    cyc(2);

    // R6: disabled pins report nothing and lose stored edges
    tag = "R6";
    en = 8'hF0;
    cyc(1); look("R6", 8'hF0);
    en = '1;
    cyc(1); look("R6", 8'hF0);
    eoi_wr = 1; eoi_d = '1;
    cyc(1); eoi_wr = 0;

    // R7: polarity flips on still pins give no event
    tag = "R7";
    for (int k = 0; k < 6; k++) begin
      pol = ~pol;
      cyc(1);
    end
    look("R7", 8'h00);
    // both-edge emulation: flip after each event
    pol = 8'h00; pin = 8'h00;
    cyc(1); look("R7", 8'hFF);
    eoi_wr = 1; eoi_d = '1; pol = '1;
    cyc(1); eoi_wr = 0; look("R7", 8'h00);
    pin = '1;
    cyc(1); look("R7", 8'hFF);

    // R8: new edge and clear in the same clock, edge wins
    tag = "R8";
    eoi_wr = 1; eoi_d = '1;
    cyc(1); eoi_wr = 0; pin = 8'h00;
    cyc(1); pin = 8'h3C; eoi_wr = 1; eoi_d = '1;
    cyc(1); eoi_wr = 0; look("R8", 8'h3C);

    // R9: mixed pseudo-random traffic against the model
    tag = "R9";
    lf = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      pin = lf[7:0];
      if (lf[8])  pol  = lf[15:8];
      if (lf[16] && lf[17]) typ = lf[23:16];
      if (lf[24] && lf[25]) en = lf[31:24] | 8'h81;
      if (lf[26]) mask = lf[13:6];
      eoi_wr = lf[27];
      eoi_d  = lf[28] ? 8'hFF : lf[20:13];
      cyc(1);
    end
    eoi_wr = 0;
    cyc(2);
    finish_run();
  end
endmodule